// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller. It serves a parameterised number of pins, 64 by default and 96 as the other supported size. The pins are split into 32-bit banks. A simple single-cycle register bus accesses it: a byte address, a write enable, 32-bit write data and combinational 32-bit read data. Each pin has an output-enable, an output value and an input level. One interrupt line summarises all pending edge events.

Registers are grouped by function. All banks of one function sit at consecutive word addresses. Pin outputs never take a written value directly: software writes a mask to a set register or to a clear register, and only the 1 bits act. Every input passes through a two-flop synchroniser. A pin latches a sticky status bit when it sees an enabled rising or falling transition. Software removes that bit by writing 1 to it.

This block has no sequencing, so it has no state machine. Its only states are the per-bit register values named in the requirements. The flow is: bus write, then register update, then pin outputs. The input path runs: pin, two sync stages, previous-level stage, then edge status.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The word index is `fn*NREG + bank`, where NREG = PIN_COUNT/32 and the byte address is 4 × the word index. Bit `p%32` of bank `p/32` belongs to pin p. The function codes are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status.
- R2: A read of the level register returns the synchronised pin inputs. A pin change driven before clock edge k becomes readable after edge k+1. Writes to the level register have no effect.
- R3: The direction register can be read and written. A 1 bit drives the pin's `pin_oe` high and a 0 bit makes the pin an input.
- R4: Writing to the set register drives `pin_out` high for every 1 bit and leaves pins under 0 bits unchanged. The set register reads as zero.
- R5: Writing to the clear register drives `pin_out` low for every 1 bit and leaves pins under 0 bits unchanged. The clear register reads as zero.
- R6: If a pin's rising-enable bit is 1, a low-to-high input change driven before edge k sets its status bit at edge k+2. The rising-enable register can be read and written.
- R7: If a pin's falling-enable bit is 1, a high-to-low change sets its status bit with the same timing. The falling-enable register can be read and written.
- R8: With both enables set, a pin captures both kinds of change. With neither enable set, it captures no change.
- R9: Writing 1 to an edge-status bit clears it. Writing 0 leaves it unchanged, and without a write a set bit stays set.
- R10: If a new edge and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R11: `irq` is the OR of every edge-status bit in every bank, with no added delay.
- R12: Some addresses are unused: word indices of 7×NREG or above, and any address whose low two bits are not 00. Writes to them change nothing and reads from them return zero.
- R13: After reset, every register, `pin_oe`, `pin_out` and `irq` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, committed at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | PIN_COUNT | Asynchronous pin input levels |
| pin_oe | output | PIN_COUNT | Per-pin output enable (1 = output) |
| pin_out | output | PIN_COUNT | Per-pin output value |
| irq | output | 1 | Summary interrupt, OR of all status bits |

## Verification
Read data is due in the same cycle as the address, so the bench samples `bus_rdata` 1 ns after it drives the address. A register write shows on `pin_oe` and `pin_out` right after the edge that commits it, and the bench checks at the following falling edge. A pin change driven at a falling edge appears in the level register after two rising edges. It appears in edge status and `irq` after three. The bench checks both sides of each boundary, and in random phases it waits three idle cycles after every pin change before it compares against its model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int BANK_BITS = 32;
    localparam int NUM_FN    = 7;

    typedef enum logic [2:0] {
        FN_LEVEL = 3'd0,
        FN_DIR   = 3'd1,
        FN_SET   = 3'd2,
        FN_CLR   = 3'd3,
        FN_RISE  = 3'd4,
        FN_FALL  = 3'd5,
        FN_STAT  = 3'd6,
        FN_NONE  = 3'd7
    } gpio_fn_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int ADDR_W = 8,
    localparam int BSEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_fn_e          fn,
    output logic [BSEL_W-1:0] bank
);
    int word;

    // R1 / R12: function-major layout, misaligned or high words decode to none
    always_comb begin
        fn   = FN_NONE;
        bank = '0;
        word = int'(addr[ADDR_W-1:2]);
        if (addr[1:0] == 2'b00 && word < NUM_FN * NREG) begin
            fn   = gpio_fn_e'(3'(word / NREG));
            bank = BSEL_W'(word % NREG);
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_BITS-1:0] level,
    input  logic [BANK_BITS-1:0] rise_en,
    input  logic [BANK_BITS-1:0] fall_en,
    input  logic [BANK_BITS-1:0] clr_mask,
    output logic [BANK_BITS-1:0] status
);
    logic [BANK_BITS-1:0] prev_q;
    logic [BANK_BITS-1:0] hit;

    // R6 / R7 / R8: compare against last cycle's synchronised level
    assign hit = (rise_en & level & ~prev_q) | (fall_en & ~level & prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            status <= '0;
        end else begin
            prev_q <= level;
            // R9 / R10: clear first, then a fresh edge wins
            status <= (status & ~clr_mask) | hit;
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 64,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic                 irq
);
    localparam int NREG   = PIN_COUNT / BANK_BITS;
    localparam int BSEL_W = (NREG > 1) ? $clog2(NREG) : 1;

    gpio_fn_e             fn;
    logic [BSEL_W-1:0]    bsel;
    logic [PIN_COUNT-1:0] lvl;
    logic [PIN_COUNT-1:0] dir_q;
    logic [PIN_COUNT-1:0] out_q;
    logic [PIN_COUNT-1:0] rise_q;
    logic [PIN_COUNT-1:0] fall_q;
    logic [PIN_COUNT-1:0] stat;

    gpio_addr_dec #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .fn   (fn),
        .bank (bsel)
    );

    gpio_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl)
    );

    // R3 / R4 / R5 / R6 / R7: register writes, level and unused ignored (R2, R12)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (bus_we) begin
            for (int b = 0; b < NREG; b++) begin
                if (bsel == BSEL_W'(b)) begin
                    unique case (fn)
                        FN_DIR:  dir_q[b*BANK_BITS +: BANK_BITS]  <= bus_wdata;
                        FN_SET:  out_q[b*BANK_BITS +: BANK_BITS]  <=
                                     out_q[b*BANK_BITS +: BANK_BITS] | bus_wdata;
                        FN_CLR:  out_q[b*BANK_BITS +: BANK_BITS]  <=
                                     out_q[b*BANK_BITS +: BANK_BITS] & ~bus_wdata;
                        FN_RISE: rise_q[b*BANK_BITS +: BANK_BITS] <= bus_wdata;
                        FN_FALL: fall_q[b*BANK_BITS +: BANK_BITS] <= bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_bank
            logic [BANK_BITS-1:0] clr;
            assign clr = (bus_we && fn == FN_STAT && bsel == BSEL_W'(g)) ? bus_wdata : '0;

            gpio_edge_bank u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .level    (lvl[g*BANK_BITS +: BANK_BITS]),
                .rise_en  (rise_q[g*BANK_BITS +: BANK_BITS]),
                .fall_en  (fall_q[g*BANK_BITS +: BANK_BITS]),
                .clr_mask (clr),
                .status   (stat[g*BANK_BITS +: BANK_BITS])
            );
        end
    endgenerate

    // R2 / R4 / R5 / R12: combinational read mux
    always_comb begin
        int base;
        base = int'(bsel) * BANK_BITS;
        unique case (fn)
            FN_LEVEL: bus_rdata = lvl[base +: BANK_BITS];
            FN_DIR:   bus_rdata = dir_q[base +: BANK_BITS];
            FN_RISE:  bus_rdata = rise_q[base +: BANK_BITS];
            FN_FALL:  bus_rdata = fall_q[base +: BANK_BITS];
            FN_STAT:  bus_rdata = stat[base +: BANK_BITS];
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_oe  = dir_q;
    assign pin_out = out_q;
    assign irq     = |stat;   // R11
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int PIN_COUNT = 64,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic                 irq
);
    localparam int NREG = PIN_COUNT / 32;

    int       widx;
    int       kind;
    int       bnk;
    int       last_kind;
    int       last_bank;
    logic [31:0] last_data;

    always_comb begin
        widx = int'(bus_addr[ADDR_W-1:2]);
        if (bus_addr[1:0] != 2'b00 || widx >= 7 * NREG) begin
            kind = 7;
            bnk  = 0;
        end else begin
            kind = widx / NREG;
            bnk  = widx % NREG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_kind <= 7;
            last_bank <= 0;
            last_data <= '0;
        end else begin
            last_kind <= bus_we ? kind : 7;
            last_bank <= bnk;
            last_data <= bus_wdata;
        end
    end

    p_dir_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_kind == 1) |-> pin_oe[last_bank*32 +: 32] == last_data);

    p_set_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_kind == 2) |-> (pin_out[last_bank*32 +: 32] & last_data) == last_data);

    p_clr_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_kind == 3) |-> (pin_out[last_bank*32 +: 32] & last_data) == 32'd0);

    p_strobe_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2 || kind == 3) |-> bus_rdata == 32'd0);

    p_unused_reads_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 7) |-> bus_rdata == 32'd0);

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_we) |=> irq);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    localparam int P    = 64;
    localparam int AW   = 8;
    localparam int NREG = P / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [P-1:0]  pin_in = '0;
    logic [P-1:0]  pin_oe;
    logic [P-1:0]  pin_out;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    logic [P-1:0] m_dir = '0, m_out = '0, m_rise = '0, m_fall = '0, m_stat = '0;

    gpio_bank_ctrl #(.PIN_COUNT(P), .ADDR_W(AW)) dut (.*);

    always #5 clk = ~clk;

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [AW-1:0] adr(int fn, int bank);
        return AW'((fn * NREG + bank) * 4);
    endfunction

    task automatic chk(string req, logic [P-1:0] act, logic [P-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    function automatic logic [P-1:0] rnd_vec();
        logic [P-1:0] v;
        for (int b = 0; b < NREG; b++) v[b*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic drive_pins(logic [P-1:0] nv);
        @(negedge clk);
        m_stat |= (m_rise & ~pin_in & nv) | (m_fall & pin_in & ~nv);
        pin_in = nv;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_outputs(string tag);
        #1;
        chk({tag, " R3 pin_oe"}, pin_oe, m_dir);
        chk({tag, " R4/R5 pin_out"}, pin_out, m_out);
        chk({tag, " R11 irq"}, P'(irq), P'(|m_stat));
    endtask

    task automatic scan_regs(string tag);
        logic [31:0] d;
        for (int b = 0; b < NREG; b++) begin
            rd(adr(0, b), d); chk({tag, " R2 level"}, P'(d), P'(pin_in[b*32 +: 32]));
            rd(adr(1, b), d); chk({tag, " R3 dir"},   P'(d), P'(m_dir[b*32 +: 32]));
            rd(adr(2, b), d); chk({tag, " R4 set reads 0"}, P'(d), '0);
            rd(adr(3, b), d); chk({tag, " R5 clr reads 0"}, P'(d), '0);
            rd(adr(4, b), d); chk({tag, " R6 rise"},  P'(d), P'(m_rise[b*32 +: 32]));
            rd(adr(5, b), d); chk({tag, " R7 fall"},  P'(d), P'(m_fall[b*32 +: 32]));
            rd(adr(6, b), d); chk({tag, " R9 stat"},  P'(d), P'(m_stat[b*32 +: 32]));
        end
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'h1A2B3C4D));

        repeat (3) @(negedge clk);
        // R13: reset state
        check_outputs("R13 reset");
        rd(adr(6, 0), d); chk("R13 stat after reset", P'(d), '0);
        rst_n = 1'b1;
        @(negedge clk);
        scan_regs("R13 post-reset");

        // R1 / R3: direction in upper bank lands on upper pins
        wr(adr(1, 1), 32'h8000_0001); m_dir[63:32] = 32'h8000_0001;
        check_outputs("R1 bank1 dir");

        // R4 / R5: set then clear with zero bits untouched
        wr(adr(2, 0), 32'h0000_00F0); m_out[31:0] |= 32'h0000_00F0;
        wr(adr(3, 0), 32'h0000_0030); m_out[31:0] &= ~32'h0000_0030;
        check_outputs("R4/R5 set-clear");

        // R2: writes to level have no effect
        wr(adr(0, 0), 32'hFFFF_FFFF);
        check_outputs("R2 level write");
        scan_regs("R2 level write");

        // R12: unused and misaligned addresses
        wr(AW'(7 * NREG * 4), 32'hFFFF_FFFF);
        wr(adr(1, 0) | AW'(1), 32'hFFFF_FFFF);
        check_outputs("R12 unused write");
        rd(AW'(7 * NREG * 4), d); chk("R12 unused read", P'(d), '0);
        rd(adr(1, 1) | AW'(2), d); chk("R12 misaligned read", P'(d), '0);

        // R2 / R6 / R11: exact latency of level and edge status
        wr(adr(4, 0), 32'h0000_0020); m_rise[31:0] = 32'h0000_0020;
        @(negedge clk);
        bus_addr = adr(0, 0);
        pin_in[5] = 1'b1;
        @(negedge clk); #1 chk("R2 level not yet after 1 edge", P'(bus_rdata[5]), P'(1'b0));
        @(negedge clk); #1 chk("R2 level after 2 edges", P'(bus_rdata[5]), P'(1'b1));
        chk("R6 no status after 2 edges", P'(irq), P'(1'b0));
        @(negedge clk); #1 chk("R6 status after 3 edges", P'(irq), P'(1'b1));
        m_stat[5] = 1'b1;
        rd(adr(6, 0), d); chk("R6 stat bit", P'(d), P'(32'h20));

        // R9: write 0 keeps, write 1 clears
        wr(adr(6, 0), 32'h0000_0000);
        rd(adr(6, 0), d); chk("R9 zero write keeps", P'(d), P'(32'h20));

        // R10: clear and new edge in the same cycle
        drive_pins(pin_in & ~(P'(1) << 5));      // falling, not enabled
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = adr(6, 0); bus_wdata = 32'h20; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(adr(6, 0), d); chk("R10 edge beats clear", P'(d), P'(32'h20));
        wr(adr(6, 0), 32'h20); m_stat[5] = 1'b0;
        rd(adr(6, 0), d); chk("R9 clear", P'(d), '0);
        check_outputs("R9/R11 cleared");

        // R7 / R8: falling only, both, none
        wr(adr(4, 0), 32'h0); m_rise[31:0] = 32'h0;
        wr(adr(5, 0), 32'h1); m_fall[31:0] = 32'h1;
        wr(adr(4, 1), 32'h2); m_rise[63:32] = 32'h2;
        wr(adr(5, 1), 32'h2); m_fall[63:32] = 32'h2;
        drive_pins(pin_in | P'(1) | (P'(1) << 33) | (P'(1) << 40));
        drive_pins(pin_in & ~(P'(1) | (P'(1) << 33) | (P'(1) << 40)));
        rd(adr(6, 0), d); chk("R7 falling captured", P'(d), P'(m_stat[31:0]));
        rd(adr(6, 1), d); chk("R8 both/none", P'(d), P'(m_stat[63:32]));
        chk("R8 expected bank1 bits", P'(m_stat[63:32]), P'(32'h2));

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op, b;
            logic [31:0] v;
            op = $urandom_range(0, 6);
            b  = $urandom_range(0, NREG - 1);
            v  = $urandom;
            unique case (op)
                0: begin wr(adr(1, b), v); m_dir[b*32 +: 32] = v; end
                1: begin wr(adr(2, b), v); m_out[b*32 +: 32] |= v; end
                2: begin wr(adr(3, b), v); m_out[b*32 +: 32] &= ~v; end
                3: begin wr(adr(4, b), v); m_rise[b*32 +: 32] = v; end
                4: begin wr(adr(5, b), v); m_fall[b*32 +: 32] = v; end
                5: begin wr(adr(6, b), v); m_stat[b*32 +: 32] &= ~v; end
                default: drive_pins(rnd_vec());
            endcase
            check_outputs("rand");
            if (it % 50 == 49) scan_regs("rand");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule